// File: doc/BRIEF.md
# Extended Register Operand Unit

This unit forms the second source operand of an integer datapath that is 64 bits wide. In extend mode it takes the low byte, halfword, word or doubleword of a register value and zero- or sign-extends it. It also applies a small left shift of 0 to 4 places and limits the result to a 32-bit or 64-bit operation width. In shift mode the same register value passes through a barrel shifter. That shifter supports logical left, logical right, arithmetic right and rotate right, and it reduces the shift amount modulo the operation width.

The operand logic is combinational. One register stage sits at the output: a request presented with `in_valid` high is captured on a rising clock edge, and its result appears on the outputs for the cycle that follows. In extend mode, a shift amount greater than 4 raises `shamt_err` and forces the result to zero.

Top module: `xop_unit`

## Requirements
- R1: In extend mode (`op_sel`=0), `ext_kind[1:0]` selects the field length: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. `ext_kind[2]`=0 selects zero extension. The result is the low field of `src`, shifted left by `amt`, with zeros above the field.
- R2: When `ext_kind[2]`=1 (sign extension), the bit at position len+amt-1 of the shifted field is copied into every higher bit, up to the operation width.
- R3: The field length actually used is the type's length or (width - `amt`), whichever is smaller.
- R4: With `wide`=0 the operation width is 32 and bits 63:32 of `result` are zero in both modes. With `wide`=1 the width is 64.
- R5: In extend mode an `amt` above 4 sets `shamt_err` and makes `result` zero. In shift mode `shamt_err` is always 0.
- R6: In shift mode (`op_sel`=1), `sh_kind` selects 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. The amount used is `amt` modulo the width (the low 5 bits when `wide`=0).
- R7: In shift mode, an effective amount of zero returns the low width bits of `src` unchanged, for every `sh_kind`.
- R8: An arithmetic right shift fills the vacated bits with bit (width-1) of the input.
- R9: `out_valid`, `result` and `shamt_err` are zero during reset. A request captured on a rising edge with `in_valid` high appears on the outputs one cycle later with `out_valid` high. After an edge where `in_valid` is low, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present; enables capture of the result |
| op_sel | input | 1 | 0 extend mode, 1 shift mode |
| wide | input | 1 | 1 selects 64-bit width, 0 selects 32-bit width |
| src | input | 64 | Register value |
| ext_kind | input | 3 | Extend type: bit 2 signed, bits 1:0 length code |
| sh_kind | input | 2 | Shift type in shift mode |
| amt | input | 6 | Shift amount |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Operand result |
| shamt_err | output | 1 | Extend-mode amount above 4 |

## Verification
The assertions assume that the request fields are stable and known whenever `in_valid` is high. They also assume that properties over `src` and `amt` compare against the values that were present at the capturing edge. The bench changes its inputs only on falling edges and presents at most one request per cycle. It covers every extend type at amounts 0 through 5 and at both widths. In shift mode it covers all four kinds at amounts of zero, in range, and above 31 for the narrow width.

// File: rtl/xop_pkg.sv
package xop_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  typedef enum logic {
    MODE_EXT   = 1'b0,
    MODE_SHIFT = 1'b1
  } op_mode_e;
endpackage

// File: rtl/xop_extend.sv
module xop_extend #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned NARROW_W  = 32,
  parameter int unsigned MAX_SHIFT = 4,
  parameter int unsigned AMT_W     = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [2:0]        kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              wide,
  output logic [DATA_W-1:0] res,
  output logic              err
);
  import xop_pkg::*;

  localparam int unsigned LEN_W = AMT_W + 1;

  logic [LEN_W-1:0]  type_len, op_w, sh_l, room, eff_len, top;
  logic [AMT_W-1:0]  sign_idx;
  logic              sign_fill;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    err      = (amt > AMT_W'(MAX_SHIFT));
    type_len = LEN_W'(BYTE_W) << kind[1:0];
    op_w     = wide ? LEN_W'(DATA_W) : LEN_W'(NARROW_W);
    sh_l     = err ? '0 : LEN_W'(amt);
    room     = op_w - sh_l;
    eff_len  = (type_len < room) ? type_len : room;
    top      = eff_len + sh_l;
    sign_idx = AMT_W'(eff_len - LEN_W'(1));
    sign_fill = kind[2] & src[sign_idx];
    shifted  = src << sh_l;
    for (int i = 0; i < DATA_W; i++) begin
      if (LEN_W'(i) >= op_w)      res[i] = 1'b0;
      else if (LEN_W'(i) < top)   res[i] = shifted[i];
      else                        res[i] = sign_fill;
    end
    if (err) res = '0;
  end
endmodule

// File: rtl/xop_shift.sv
module xop_shift #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned AMT_W    = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [1:0]        kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              wide,
  output logic [DATA_W-1:0] res
);
  import xop_pkg::*;

  localparam int unsigned NAMT_W = $clog2(NARROW_W);

  shift_kind_e         k;
  logic [NAMT_W-1:0]   a_n;
  logic [NARROW_W-1:0] x_n, r_n;
  logic [DATA_W-1:0]   r_w;
  logic [2*DATA_W-1:0]   rot_w;
  logic [2*NARROW_W-1:0] rot_n;

  always_comb begin
    k     = shift_kind_e'(kind);
    a_n   = amt[NAMT_W-1:0];
    x_n   = src[NARROW_W-1:0];
    rot_w = {src, src} >> amt;
    rot_n = {x_n, x_n} >> a_n;
    unique case (k)
      SH_LSL: begin r_w = src << amt;  r_n = x_n << a_n; end
      SH_LSR: begin r_w = src >> amt;  r_n = x_n >> a_n; end
      SH_ASR: begin
        r_w = DATA_W'($signed(src) >>> amt);
        r_n = NARROW_W'($signed(x_n) >>> a_n);
      end
      default: begin
        r_w = rot_w[DATA_W-1:0];
        r_n = rot_n[NARROW_W-1:0];
      end
    endcase
    res = wide ? r_w : {{(DATA_W-NARROW_W){1'b0}}, r_n};
  end
endmodule

// File: rtl/xop_stage.sv
module xop_stage #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] d_res,
  input  logic              d_err,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_res,
  output logic              q_err
);
  logic              nxt_valid, nxt_err;
  logic [DATA_W-1:0] nxt_res;

  always_comb begin
    nxt_valid = en;
    nxt_res   = en ? d_res : q_res;
    nxt_err   = en ? d_err : q_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_res   <= '0;
      q_err   <= 1'b0;
    end else begin
      q_valid <= nxt_valid;
      q_res   <= nxt_res;
      q_err   <= nxt_err;
    end
  end
endmodule

// File: rtl/xop_unit.sv
module xop_unit #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned NARROW_W  = 32,
  parameter int unsigned MAX_SHIFT = 4,
  parameter int unsigned AMT_W     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              op_sel,
  input  logic              wide,
  input  logic [DATA_W-1:0] src,
  input  logic [2:0]        ext_kind,
  input  logic [1:0]        sh_kind,
  input  logic [AMT_W-1:0]  amt,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              shamt_err
);
  import xop_pkg::*;

  logic [DATA_W-1:0] ext_res, sh_res, sel_res;
  logic              ext_err, sel_err;

  xop_extend #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .MAX_SHIFT(MAX_SHIFT), .AMT_W(AMT_W)) u_ext (
    .src(src), .kind(ext_kind), .amt(amt), .wide(wide), .res(ext_res), .err(ext_err)
  );

  xop_shift #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .AMT_W(AMT_W)) u_sh (
    .src(src), .kind(sh_kind), .amt(amt), .wide(wide), .res(sh_res)
  );

  always_comb begin
    if (op_mode_e'(op_sel) == MODE_SHIFT) begin
      sel_res = sh_res;
      sel_err = 1'b0;
    end else begin
      sel_res = ext_res;
      sel_err = ext_err;
    end
  end

  xop_stage #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .en(in_valid),
    .d_res(sel_res), .d_err(sel_err),
    .q_valid(out_valid), .q_res(result), .q_err(shamt_err)
  );
endmodule

// File: rtl/xop_unit_chk.sv
module xop_unit_chk #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned AMT_W    = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              op_sel,
  input logic              wide,
  input logic [DATA_W-1:0] src,
  input logic [2:0]        ext_kind,
  input logic [AMT_W-1:0]  amt,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              shamt_err
);
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> (result[DATA_W-1:NARROW_W] == '0));
  assert_big_amount_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_sel && amt > AMT_W'(4)) |=> (shamt_err && result == '0));
  assert_shift_no_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel) |=> !shamt_err);
  assert_zero_amount_identity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel && wide && amt == '0) |=> (result == $past(src)));
  assert_byte_zero_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_sel && ext_kind == 3'd0 && amt == '0) |=>
    (result == {{(DATA_W-8){1'b0}}, $past(src[7:0])}));
endmodule

bind xop_unit xop_unit_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .AMT_W(AMT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel), .wide(wide),
  .src(src), .ext_kind(ext_kind), .amt(amt), .out_valid(out_valid),
  .result(result), .shamt_err(shamt_err)
);

// File: tb/xop_unit_tb.sv
module xop_unit_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] res;
    logic        err;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, op_sel, wide;
  logic [63:0] src;
  logic [2:0]  ext_kind;
  logic [1:0]  sh_kind;
  logic [5:0]  amt;
  logic        out_valid, shamt_err;
  logic [63:0] result;

  int   n_checks = 0;
  int   n_fails  = 0;
  bit   finished = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xop_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel), .wide(wide),
    .src(src), .ext_kind(ext_kind), .sh_kind(sh_kind), .amt(amt),
    .out_valid(out_valid), .result(result), .shamt_err(shamt_err)
  );

  function automatic logic [63:0] lowmask(int n);
    if (n >= 64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp_v);
    n_checks++;
    if (act !== exp_v) begin
      n_fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic drive_ext(logic [2:0] k, logic [5:0] s, logic w, logic [63:0] v, string tag);
    exp_t e;
    int   width, len;
    logic [63:0] tmp;
    width = w ? 64 : 32;
    if (s > 6'd4) begin
      e.res = '0; e.err = 1'b1;
    end else begin
      len = 8 << k[1:0];
      if (len > width - int'(s)) len = width - int'(s);
      tmp = (v & lowmask(len)) << s;
      if (k[2] && tmp[len + int'(s) - 1]) tmp = tmp | ~lowmask(len + int'(s));
      e.res = tmp & lowmask(width); e.err = 1'b0;
    end
    e.tag = tag;
    @(negedge clk);
    in_valid = 1'b1; op_sel = 1'b0; wide = w; src = v; ext_kind = k; amt = s; sh_kind = 2'd0;
    sb.push_back(e);
  endtask

  task automatic drive_sh(logic [1:0] k, logic [5:0] a, logic w, logic [63:0] v, string tag);
    exp_t e;
    int   width, n;
    logic [63:0] x, r;
    width = w ? 64 : 32;
    n = int'(a) % width;
    x = v & lowmask(width);
    if (n == 0) r = x;
    else case (k)
      2'd0: r = x << n;
      2'd1: r = x >> n;
      2'd2: r = (x >> n) | (x[width-1] ? ~lowmask(width - n) : 64'd0);
      default: r = (x >> n) | (x << (width - n));
    endcase
    e.res = r & lowmask(width); e.err = 1'b0; e.tag = tag;
    @(negedge clk);
    in_valid = 1'b1; op_sel = 1'b1; wide = w; src = v; sh_kind = k; amt = a; ext_kind = 3'd0;
    sb.push_back(e);
  endtask

  // Monitor: pops one expected item for every valid output
  always @(negedge clk) begin
    if (rst_n && out_valid && !finished) begin
      if (sb.size() == 0) begin
        n_checks++; n_fails++;
        $display("FAIL R9 unexpected out_valid: actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " result"}, result, e.res);
        check({e.tag, " shamt_err"}, {63'd0, shamt_err}, {63'd0, e.err});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fails++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_sel = 1'b0; wide = 1'b1;
    src = '0; ext_kind = '0; sh_kind = '0; amt = '0;
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R9 reset result", result, 64'd0);
    check("R9 reset shamt_err", {63'd0, shamt_err}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", {63'd0, out_valid}, 64'd0);

    drive_ext(3'd0, 6'd0, 1'b1, 64'h1234_5678_9ABC_DEF0, "R1 ubyte");
    drive_ext(3'd1, 6'd2, 1'b1, 64'h1234_5678_9ABC_DEF0, "R1 uhalf shl2");
    drive_ext(3'd2, 6'd3, 1'b1, 64'hFFFF_FFFF_8000_0001, "R1 uword shl3");
    drive_ext(3'd4, 6'd0, 1'b1, 64'h0000_0000_0000_0080, "R2 sbyte neg");
    drive_ext(3'd5, 6'd4, 1'b1, 64'h0000_0000_0000_8001, "R2 shalf neg shl4");
    drive_ext(3'd5, 6'd1, 1'b1, 64'hFFFF_FFFF_FFFF_7FFF, "R2 shalf pos");
    drive_ext(3'd6, 6'd0, 1'b0, 64'hAAAA_AAAA_8765_4321, "R4 sword narrow");
    drive_ext(3'd3, 6'd1, 1'b1, 64'hC000_0000_0000_0001, "R3 udword clamp");
    drive_ext(3'd7, 6'd2, 1'b1, 64'h2000_0000_0000_0003, "R3 sdword clamp sign");
    drive_ext(3'd2, 6'd3, 1'b0, 64'h0000_0000_F000_0001, "R3 uword narrow clamp");
    drive_ext(3'd6, 6'd4, 1'b0, 64'h0000_0000_0800_0000, "R3 sword narrow clamp sign");
    drive_ext(3'd0, 6'd5, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R5 amt5 err");
    drive_ext(3'd7, 6'd63, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R5 amt63 err");

    drive_sh(2'd0, 6'd4, 1'b1, 64'hF000_0000_0000_000F, "R6 lsl wide");
    drive_sh(2'd1, 6'd63, 1'b1, 64'h8000_0000_0000_0000, "R6 lsr wide 63");
    drive_sh(2'd3, 6'd8, 1'b1, 64'h0123_4567_89AB_CDEF, "R6 ror wide");
    drive_sh(2'd0, 6'd40, 1'b0, 64'hFFFF_FFFF_0000_00FF, "R6 lsl narrow mod32");
    drive_sh(2'd3, 6'd36, 1'b0, 64'h5555_5555_1234_5678, "R6 ror narrow mod32");
    drive_sh(2'd2, 6'd4, 1'b1, 64'h8000_0000_0000_0000, "R8 asr wide neg");
    drive_sh(2'd2, 6'd8, 1'b0, 64'h0000_0000_8000_0000, "R8 asr narrow neg");
    drive_sh(2'd2, 6'd8, 1'b0, 64'hFFFF_FFFF_7000_0000, "R8 asr narrow pos");
    for (int k = 0; k < 4; k++) begin
      drive_sh(2'(k), 6'd0, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, "R7 zero amt wide");
      drive_sh(2'(k), 6'd32, 1'b0, 64'hDEAD_BEEF_CAFE_F00D, "R7 zero amt narrow");
    end

    for (int k = 0; k < 8; k++)
      for (int s = 0; s < 6; s++)
        for (int w = 0; w < 2; w++)
          drive_ext(3'(k), 6'(s), 1'(w),
                    (w != 0) ? 64'hF0E1_D2C3_B4A5_9687 : 64'h0F1E_2D3C_4B5A_6978 ^ 64'(k * 8'h11),
                    "R3 extend sweep");

    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 idle after stream", {63'd0, out_valid}, 64'd0);
    check("R9 all results drained", 64'(sb.size()), 64'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule